// File: doc/BRIEF.md
# Expansion Bus Arbitration Interface

This block lets one repeater device share a 5-bit expansion data bus with other devices. An external arbiter decides which device may drive the bus. When the local core wants to transmit, the block raises an activity request. The arbiter answers with an active-low enable. The block accepts that enable only after it has stayed asserted for a programmable number of clock cycles. It then raises an acknowledge. On the next cycle it starts driving symbols onto the bus and forwards its clock with them.

The block also handles the jam signals of the stack. An incoming forced-jam line is synchronized and filtered before it is sent to the local ports as a jam command. The outgoing jam line is the OR of the per-port carrier-integrity jam requests and the internal collision flag. The incoming forced jam is never looped back onto it.

Three inputs are asynchronous to the local clock: the arbiter enable, the forced-jam input and the expansion carrier sense. Each passes through a multi-flop synchronizer. After a local collision ends, enables from the arbiter are ignored until the local activity request drops. This stops a device that has just collided from grabbing the bus again in the middle of the same transmit attempt.

Top module: `xbus_arb_if`

## Requirements
- R1: While reset is asserted and after its release, with all inputs idle (enable high, everything else low), the outputs `any_act_o`, `ack_o`, `bus_oe_o`, `bus_clk_o`, `jam_o`, `jam_local_o`, `xact_o` are 0 and `bus_dat_o` is 0.
- R2: `any_act_o` equals `tx_req_i` delayed by one clock.
- R3: With `long_qual_i`=0, the enable `bus_en_n_i` (active low) is accepted only after 2 consecutive sampled low cycles. If it is held low from just before edge k for L cycles, `ack_o` is 1 exactly after edges k+4 through k+L+2 when L≥2, and it never rises when L<2.
- R4: With `long_qual_i`=1, the enable needs 4 consecutive sampled low cycles. `ack_o` is 1 exactly after edges k+6 through k+L+2 when L≥4, and it never rises when L<4.
- R5: `ack_o` rises on the clock edge after qualification. It falls on the first edge after the qualified enable goes away, which is edge k+L+3 for a pulse of L cycles.
- R6: `bus_oe_o` is 1 only while `ack_o` is 1. It rises one edge after `ack_o` rises and falls on the same edge as `ack_o`. While it is 1, `bus_dat_o` equals the `tx_sym_i` value sampled at the previous edge. Otherwise `bus_dat_o` is 0.
- R7: `bus_clk_o` follows `clk` while `bus_oe_o` is 1 and is held low otherwise.
- R8: `jam_local_o` goes to 1 after `fjam_i` has been sampled high on 2 consecutive cycles. For a pulse of L cycles starting before edge k, it is 1 after edges k+3 through k+L+1 when L≥2, and never when L<2.
- R9: `jam_o` equals the OR of all `port_jam_i` bits and `coll_i`, delayed by one clock. `fjam_i` has no effect on it.
- R10: If `coll_i` falls while `tx_req_i` is 1, the enable is ignored until `tx_req_i` is sampled low. `ack_o` and `bus_oe_o` drop within two edges and stay low even while the enable is held. An enable held during the collision itself is still honored. A collision that ends while `tx_req_i` is 0 blocks nothing.
- R11: `xact_o` is `xcrs_i` after the two-stage synchronizer: it changes after the second edge that samples the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local symbol clock |
| rst_n | input | 1 | Synchronous reset, active low |
| long_qual_i | input | 1 | 1 selects the 4-cycle enable qualification, 0 the 2-cycle one |
| tx_req_i | input | 1 | Local core wants to transmit on the expansion bus |
| tx_sym_i | input | SYM_W | Symbol to place on the bus |
| bus_en_n_i | input | 1 | Arbiter enable, active low, asynchronous |
| fjam_i | input | 1 | Forced jam from the stack, asynchronous |
| xcrs_i | input | 1 | Expansion carrier sense, asynchronous |
| port_jam_i | input | N_PORTS | Per-port carrier-integrity jam requests |
| coll_i | input | 1 | Internal collision flag |
| any_act_o | output | 1 | Activity request to the arbiter |
| ack_o | output | 1 | Acknowledge of a qualified enable |
| bus_oe_o | output | 1 | Output enable for the expansion data pins |
| bus_dat_o | output | SYM_W | Symbol driven onto the bus |
| bus_clk_o | output | 1 | Forwarded bus clock |
| jam_o | output | 1 | Jam request out to the stack |
| jam_local_o | output | 1 | Qualified forced jam toward the local ports |
| xact_o | output | 1 | Synchronized expansion carrier sense |

## Verification
The hardest case to reach is the post-collision lockout. The bench has to hold the arbiter enable low, let the acknowledge come up, then raise and drop the collision flag while the local request is still high. It then has to watch that the acknowledge stays down for many cycles even though the enable is still present. After that the bench drops the request and checks the exact cycle in which the acknowledge comes back. The same sequence is repeated with the request low, to show that a collision ending outside a transmit attempt blocks nothing. The enable and forced-jam filters are swept over every pulse length up to two cycles past their threshold, in both qualification modes. At every cycle the expected acknowledge, output enable and symbol are computed from the pulse length.

// File: rtl/xbus_pkg.sv
// Shared types for the expansion bus arbitration interface.
package xbus_pkg;

    // Asynchronous inputs grouped for a single synchronizer bank.
    typedef struct packed {
        logic en_n;   // arbiter enable, active low
        logic fjam;   // forced jam from the stack
        logic xcrs;   // expansion carrier sense
    } xin_t;

    // Idle value of the asynchronous inputs (enable released).
    localparam xin_t XIN_IDLE = '{en_n: 1'b1, fjam: 1'b0, xcrs: 1'b0};

    // Larger of two integers, used to size the qualification counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/xbus_sync.sv
// Multi-flop synchronizer bank.
// Assumes: each bit is an independent level signal. No bus coherency is implied.
module xbus_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    // Shift every input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
        end
    end

    assign q_o = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/xbus_filt.sv
// Level qualifier: the output rises once the input has been high for
// need_i consecutive samples, and falls on the first low sample.
// Assumes: need_i >= 1 and need_i <= CNT_MAX.
module xbus_filt #(
    parameter int CNT_MAX = 4,
    localparam int CW     = $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic [CW-1:0] need_i,
    output logic          qual_o
);
    localparam logic [CW-1:0] CMAX = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_inc;
    logic          qual_q;

    // Saturating increment of the run length.
    always_comb begin
        cnt_inc = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
    end

    // Track the current run of high samples and compare it with the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!lvl_i) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_inc;
            qual_q <= (cnt_inc >= need_i);
        end
    end

    assign qual_o = qual_q;
endmodule

// File: rtl/xbus_colmask.sv
// Post-collision lockout: once a collision ends during a local transmit
// request, block_o stays high until the request is sampled low.
// Assumes: coll_i and req_i are synchronous to clk.
module xbus_colmask (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic coll_i,
    output logic block_o
);
    logic coll_d;
    logic blk_q;

    // Delay the collision flag to detect its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) coll_d <= 1'b0;
        else        coll_d <= coll_i;
    end

    // Set on a collision end while requesting; clear once the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= 1'b0;
        else        blk_q <= req_i & (blk_q | (coll_d & ~coll_i));
    end

    assign block_o = blk_q;
endmodule

// File: rtl/xbus_arb_if.sv
// Expansion bus arbitration interface top.
// Synchronizes the arbiter inputs, qualifies enable and forced jam,
// runs the acknowledge-then-drive sequence, and forms the jam output.
// Assumes: clk is the local symbol clock; tx_req_i, tx_sym_i, port_jam_i
// and coll_i are synchronous to it.
module xbus_arb_if
    import xbus_pkg::*;
#(
    parameter int SYM_W       = 5,
    parameter int N_PORTS     = 5,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_SHORT  = 2,
    parameter int QUAL_LONG   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               long_qual_i,
    input  logic               tx_req_i,
    input  logic [SYM_W-1:0]   tx_sym_i,
    input  logic               bus_en_n_i,
    input  logic               fjam_i,
    input  logic               xcrs_i,
    input  logic [N_PORTS-1:0] port_jam_i,
    input  logic               coll_i,
    output logic               any_act_o,
    output logic               ack_o,
    output logic               bus_oe_o,
    output logic [SYM_W-1:0]   bus_dat_o,
    output logic               bus_clk_o,
    output logic               jam_o,
    output logic               jam_local_o,
    output logic               xact_o
);
    localparam int CNT_MAX = imax(QUAL_SHORT, QUAL_LONG);
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] NEED_S = CW'(QUAL_SHORT);
    localparam logic [CW-1:0] NEED_L = CW'(QUAL_LONG);
    localparam int N_FILT  = 2;   // 0: enable, 1: forced jam

    xin_t raw_in;
    xin_t syn_in;
    logic coll_block;
    logic en_act;
    logic [N_FILT-1:0]  filt_lvl;
    logic [CW-1:0]      filt_need [N_FILT];
    logic [N_FILT-1:0]  filt_qual;

    logic               ack_q;
    logic               drive_q;
    logic [SYM_W-1:0]   sym_q;
    logic               any_act_q;
    logic               jam_q;

    assign raw_in = '{en_n: bus_en_n_i, fjam: fjam_i, xcrs: xcrs_i};

    xbus_sync #(
        .WIDTH   ($bits(xin_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (XIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    xbus_colmask u_colmask (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (tx_req_i),
        .coll_i  (coll_i),
        .block_o (coll_block)
    );

    // Active-high enable, masked by the post-collision lockout.
    assign en_act = ~syn_in.en_n & ~coll_block;

    assign filt_lvl[0]  = en_act;
    assign filt_need[0] = long_qual_i ? NEED_L : NEED_S;
    assign filt_lvl[1]  = syn_in.fjam;
    assign filt_need[1] = NEED_S;

    generate
        for (genvar g = 0; g < N_FILT; g++) begin : g_filt
            xbus_filt #(
                .CNT_MAX (CNT_MAX)
            ) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .lvl_i  (filt_lvl[g]),
                .need_i (filt_need[g]),
                .qual_o (filt_qual[g])
            );
        end
    endgenerate

    // Acknowledge follows the qualified enable by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= filt_qual[0];
    end

    // Drive starts the edge after ack and stops together with it.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= filt_qual[0] & ack_q;
    end

    // Register the outgoing symbol every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sym_q <= '0;
        else        sym_q <= tx_sym_i;
    end

    // Activity request and outgoing jam, one cycle of latency each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_act_q <= 1'b0;
            jam_q     <= 1'b0;
        end else begin
            any_act_q <= tx_req_i;
            jam_q     <= (|port_jam_i) | coll_i;
        end
    end

    assign any_act_o   = any_act_q;
    assign ack_o       = ack_q;
    assign bus_oe_o    = drive_q;
    assign bus_dat_o   = drive_q ? sym_q : '0;
    assign bus_clk_o   = drive_q & clk;
    assign jam_o       = jam_q;
    assign jam_local_o = filt_qual[1];
    assign xact_o      = syn_in.xcrs;
endmodule

// File: rtl/xbus_arb_if_chk.sv
// Assertion checker for xbus_arb_if, attached by bind.
module xbus_arb_if_chk #(
    parameter int SYM_W   = 5,
    parameter int N_PORTS = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_req_i,
    input logic [N_PORTS-1:0] port_jam_i,
    input logic               coll_i,
    input logic               any_act_o,
    input logic               ack_o,
    input logic               bus_oe_o,
    input logic [SYM_W-1:0]   bus_dat_o,
    input logic               jam_o,
    input logic               en_act,
    input logic               coll_block
);
    p_act_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (any_act_o == $past(tx_req_i)));

    p_ack_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> ($past(en_act, 2) && $past(en_act, 3)));

    p_oe_within_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> ack_o);

    p_oe_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(ack_o));

    p_dat_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_dat_o == '0));

    p_jam_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (jam_o == $past((|port_jam_i) | coll_i)));

    p_lockout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        coll_block |-> ##2 !ack_o);
endmodule

bind xbus_arb_if xbus_arb_if_chk #(
    .SYM_W   (SYM_W),
    .N_PORTS (N_PORTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req_i   (tx_req_i),
    .port_jam_i (port_jam_i),
    .coll_i     (coll_i),
    .any_act_o  (any_act_o),
    .ack_o      (ack_o),
    .bus_oe_o   (bus_oe_o),
    .bus_dat_o  (bus_dat_o),
    .jam_o      (jam_o),
    .en_act     (en_act),
    .coll_block (coll_block)
);

// File: tb/xbus_arb_if_tb.sv
// Self-checking bench for xbus_arb_if.
module xbus_arb_if_tb;
    localparam int SYM_W   = 5;
    localparam int N_PORTS = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               long_qual_i = 1'b0;
    logic               tx_req_i = 1'b0;
    logic [SYM_W-1:0]   tx_sym_i = '0;
    logic               bus_en_n_i = 1'b1;
    logic               fjam_i = 1'b0;
    logic               xcrs_i = 1'b0;
    logic [N_PORTS-1:0] port_jam_i = '0;
    logic               coll_i = 1'b0;
    logic               any_act_o, ack_o, bus_oe_o, bus_clk_o;
    logic               jam_o, jam_local_o, xact_o;
    logic [SYM_W-1:0]   bus_dat_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xbus_arb_if u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .long_qual_i (long_qual_i),
        .tx_req_i    (tx_req_i),
        .tx_sym_i    (tx_sym_i),
        .bus_en_n_i  (bus_en_n_i),
        .fjam_i      (fjam_i),
        .xcrs_i      (xcrs_i),
        .port_jam_i  (port_jam_i),
        .coll_i      (coll_i),
        .any_act_o   (any_act_o),
        .ack_o       (ack_o),
        .bus_oe_o    (bus_oe_o),
        .bus_dat_o   (bus_dat_o),
        .bus_clk_o   (bus_clk_o),
        .jam_o       (jam_o),
        .jam_local_o (jam_local_o),
        .xact_o      (xact_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then settle 1 ns into the high phase.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #500000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3);
        chk("R1 any_act", any_act_o, 0);
        chk("R1 ack", ack_o, 0);
        chk("R1 oe", bus_oe_o, 0);
        chk("R1 dat", bus_dat_o, 0);
        chk("R1 jam", jam_o, 0);
        chk("R1 jam_local", jam_local_o, 0);
        rst_n = 1'b1;
        idle(3);
        chk("R1 ack after release", ack_o, 0);
        chk("R1 bus_clk", bus_clk_o, 0);
        chk("R1 xact", xact_o, 0);

        // R2: activity request latency
        for (int i = 0; i < 8; i++) begin
            tx_req_i = ((8'b1011_0010 >> i) & 1) != 0;
            step();
            chk("R2 any_act", any_act_o, int'(tx_req_i));
        end
        tx_req_i = 1'b0;
        step();

        // R9: exhaustive jam OR sweep, forced jam active but excluded
        fjam_i = 1'b1;
        idle(4);
        chk("R8 jam_local held", jam_local_o, 1);
        for (int v = 0; v < 64; v++) begin
            port_jam_i = v[4:0];
            coll_i     = v[5];
            step();
            chk("R9 jam_o", jam_o, int'(v != 0));
        end
        port_jam_i = '0;
        coll_i = 1'b0;
        step();
        chk("R9 fjam excluded", jam_o, 0);
        fjam_i = 1'b0;
        idle(4);

        // R3/R4/R5/R6/R7: enable pulse sweep in both modes
        for (int mode = 0; mode < 2; mode++) begin
            int need;
            need = (mode == 0) ? 2 : 4;
            long_qual_i = mode[0];
            tx_req_i = 1'b1;
            for (int len = 1; len <= need + 2; len++) begin
                for (int j = 0; j <= len + 5; j++) begin
                    logic exp_ack, exp_oe;
                    logic [SYM_W-1:0] sym;
                    bus_en_n_i = (j < len) ? 1'b0 : 1'b1;
                    sym = SYM_W'((j * 7 + len * 3 + 1) & 31);
                    tx_sym_i = sym;
                    step();
                    exp_ack = (len >= need) && (j >= need + 2) && (j <= len + 2);
                    exp_oe  = (len >= need) && (j >= need + 3) && (j <= len + 2);
                    if (mode == 0) chk("R3 ack short qual", ack_o, int'(exp_ack));
                    else           chk("R4 ack long qual", ack_o, int'(exp_ack));
                    chk("R5 ack timing", ack_o, int'(exp_ack));
                    chk("R6 oe", bus_oe_o, int'(exp_oe));
                    chk("R6 dat", bus_dat_o, exp_oe ? int'(sym) : 0);
                    chk("R7 bus_clk", bus_clk_o, int'(exp_oe));
                end
                idle(3);
            end
            tx_req_i = 1'b0;
        end
        long_qual_i = 1'b0;
        idle(3);

        // R8: forced jam pulse sweep
        for (int len = 1; len <= 4; len++) begin
            for (int j = 0; j <= len + 4; j++) begin
                fjam_i = (j < len);
                step();
                chk("R8 jam_local", jam_local_o,
                    int'((len >= 2) && (j >= 3) && (j <= len + 1)));
            end
            idle(2);
        end

        // R11: carrier sense synchronizer
        xcrs_i = 1'b1;
        step();
        chk("R11 xact first edge", xact_o, 0);
        step();
        chk("R11 xact second edge", xact_o, 1);
        xcrs_i = 1'b0;
        step();
        chk("R11 xact hold", xact_o, 1);
        step();
        chk("R11 xact fall", xact_o, 0);

        // R10: collision ends during a request -> lockout
        tx_req_i = 1'b1;
        bus_en_n_i = 1'b0;
        idle(6);
        chk("R10 ack before collision", ack_o, 1);
        coll_i = 1'b1;
        idle(3);
        chk("R10 ack during collision", ack_o, 1);
        coll_i = 1'b0;
        idle(3);
        chk("R10 ack locked out", ack_o, 0);
        for (int i = 0; i < 10; i++) begin
            step();
            chk("R10 ack stays low", ack_o, 0);
            chk("R10 oe stays low", bus_oe_o, 0);
        end
        tx_req_i = 1'b0;
        step();
        step();
        step();
        chk("R10 ack not yet back", ack_o, 0);
        step();
        chk("R10 ack back after request drop", ack_o, 1);

        // R10: collision ending with no request blocks nothing
        coll_i = 1'b1;
        idle(2);
        coll_i = 1'b0;
        idle(6);
        chk("R10 no lockout without request", ack_o, 1);
        bus_en_n_i = 1'b1;
        idle(5);
        chk("R5 ack released", ack_o, 0);

        summary();
        $finish;
    end
endmodule